// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block decides, clock by clock, when the gate of a synchronous-rectifier switch on the secondary side of a resonant converter is enabled. It sees the switch only through three comparator flags taken from the sensed drain-to-source voltage. The first says that body-diode conduction has started. The second says that the rectified current has decayed towards zero. The third says that the voltage has swung positive, which marks the start of a new switching cycle. Two identical channels run side by side, one per secondary leg, and they share the two programmed timing counts.

Once a channel sees body-diode conduction, it enables the gate. It then holds the gate for a programmed minimum on-time, so that ringing on the sensed voltage cannot end conduction too early. After that, the gate drops as soon as the turn-off flag is seen. Following turn-off, the turn-on flag is locked out, because the renewed diode drop would otherwise retrigger the gate. Only the positive-swing flag lifts this lockout, which allows one conduction per switching cycle. A programmed blanking count ends the blanking phase if no positive swing arrives in time. The lockout stays in force after that until the positive swing is seen. A one-clock status pulse marks a turn-off that was held back by the minimum on-time and released at the last cycle of that window.

Top module: `sr_gate_seq`

## Requirements
- R1: In the clock after synchronous reset is released, every channel reports state 0 (waiting for re-arm), with its gate enable at 0 and its early-off pulse at 0.
- R2: A channel in state 0 ignores the turn-on flag. A re-arm flag moves it to state 1 (armed).
- R3: Each flag passes through two synchroniser flops. A flag driven just after rising edge n takes effect in the state and gate outputs visible after edge n+3. In state 1, the turn-on flag moves the channel to state 2 (minimum on-time) and sets the gate enable.
- R4: State 2 lasts exactly M+1 clocks, where M is the minimum on-time count. The turn-off flag has no effect in any of these clocks except the last.
- R5: When the minimum on-time ends without a turn-off flag, the channel enters state 3 (on). In state 3, the turn-off flag moves the channel to state 4 (blanking) and clears the gate enable.
- R6: The turn-on flag has no effect in state 4, and the gate enable stays 0.
- R7: With no re-arm flag, state 4 lasts exactly B+1 clocks, where B is the blanking count. The channel then enters state 0.
- R8: A re-arm flag in state 4 moves the channel to state 1 at once. It takes priority over expiry of the blanking count.
- R9: A count of zero ends its window after one clock. State 2 or state 4 is then held for a single clock.
- R10: The early-off output is 1 for exactly one clock when a turn-off flag present in the last clock of state 2 sends the channel to state 4. This clock is the first clock of state 4. A turn-off from state 3 leaves the output at 0.
- R11: The minimum on-time count is sampled when state 2 is entered, and the blanking count is sampled when state 4 is entered. A change to either count after that has no effect on the running window.
- R12: Channels are independent. Channel c reports its state on bits [3c+2:3c] of the state output and uses bit c of every flag, gate and pulse vector.
- R13: The gate enable is 1 exactly when the channel is in state 2 or state 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| turn_on_flag | input | NUM_CH | Body-diode conduction detected, one bit per channel (asynchronous) |
| turn_off_flag | input | NUM_CH | Current decayed to the turn-off level, one bit per channel (asynchronous) |
| rearm_flag | input | NUM_CH | Positive swing detected, one bit per channel (asynchronous) |
| min_on_cnt | input | CNT_W | Minimum on-time count M, in clocks |
| blank_cnt | input | CNT_W | Post-turn-off blanking count B, in clocks |
| gate_en | output | NUM_CH | Gate enable per channel |
| chan_state | output | 3*NUM_CH | State code per channel (0 wait, 1 armed, 2 min-on, 3 on, 4 blanking) |
| early_off | output | NUM_CH | One-clock pulse for a turn-off released at the end of the minimum on-time |

## Verification
The hardest case to reach is a turn-off that lands exactly on the last clock of the minimum on-time window. To reach it, the bench holds the turn-off flag high from the middle of the window through its end. It also reprograms the count while the window is running, so the same run shows the pulse timing and the sampling of the count at entry. A second hard case is a re-arm that arrives inside the blanking window before it expires. The bench places the re-arm a fixed number of clocks after the turn-off, with the three-clock flag latency counted in. It then checks that the armed state appears in a clock where the blanking count has not yet run out.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

    typedef enum logic [2:0] {
        ST_WAIT  = 3'd0,
        ST_ARMED = 3'd1,
        ST_MOT   = 3'd2,
        ST_ON    = 3'd3,
        ST_BLANK = 3'd4
    } sr_state_e;

    localparam int STATE_W = 3;

endpackage

// File: rtl/sr_flag_sync.sv
module sr_flag_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg_q[g] <= '0;
                else     stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign sync_out = stg_q[STAGES-1];

endmodule

// File: rtl/sr_down_timer.sv
module sr_down_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                   cnt_d = load_val;
        else if (dec && cnt_q != 0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R11
    load_hold_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/sr_chan_fsm.sv
module sr_chan_fsm
    import sr_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               on_s,
    input  logic               off_s,
    input  logic               rearm_s,
    input  logic [CNT_W-1:0]   min_on_cnt,
    input  logic [CNT_W-1:0]   blank_cnt,
    output logic               gate_en,
    output logic [STATE_W-1:0] state_code,
    output logic               early_off
);

    typedef struct packed {
        sr_state_e state;
        logic      gate;
        logic      early;
    } fsm_regs_t;

    fsm_regs_t        cur_q, nxt_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_dec;
    logic             tmr_zero;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.early = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = min_on_cnt;
        tmr_dec     = 1'b0;
        unique case (cur_q.state)
            ST_WAIT: begin
                if (rearm_s) nxt_d.state = ST_ARMED;
            end
            ST_ARMED: begin
                if (on_s) begin
                    nxt_d.state = ST_MOT;
                    tmr_load    = 1'b1;
                    tmr_val     = min_on_cnt;
                end
            end
            ST_MOT: begin
                if (tmr_zero) begin
                    if (off_s) begin
                        nxt_d.state = ST_BLANK;
                        nxt_d.early = 1'b1;
                        tmr_load    = 1'b1;
                        tmr_val     = blank_cnt;
                    end else begin
                        nxt_d.state = ST_ON;
                    end
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_ON: begin
                if (off_s) begin
                    nxt_d.state = ST_BLANK;
                    tmr_load    = 1'b1;
                    tmr_val     = blank_cnt;
                end
            end
            ST_BLANK: begin
                if (rearm_s)       nxt_d.state = ST_ARMED;
                else if (tmr_zero) nxt_d.state = ST_WAIT;
                else               tmr_dec     = 1'b1;
            end
            default: nxt_d.state = ST_WAIT;
        endcase
        nxt_d.gate = (nxt_d.state == ST_MOT) || (nxt_d.state == ST_ON);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.state <= ST_WAIT;
            cur_q.gate  <= 1'b0;
            cur_q.early <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    sr_down_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    assign gate_en    = cur_q.gate;
    assign state_code = cur_q.state;
    assign early_off  = cur_q.early;

    // R2
    wait_lockout_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.state == ST_WAIT) |=> (cur_q.state == ST_WAIT || cur_q.state == ST_ARMED));

    // R4
    mot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.state == ST_MOT && !tmr_zero) |=> (cur_q.state == ST_MOT));

    // R6
    blank_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.state == ST_BLANK) |=> (cur_q.state != ST_MOT && !cur_q.gate));

    // R10
    early_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cur_q.early |=> !cur_q.early);

    // R10
    early_origin_chk: assert property (@(posedge clk) disable iff (rst)
        cur_q.early |-> (cur_q.state == ST_BLANK && $past(cur_q.state) == ST_MOT));

    // R13
    gate_map_chk: assert property (@(posedge clk) disable iff (rst)
        cur_q.gate == (cur_q.state == ST_MOT || cur_q.state == ST_ON));

endmodule

// File: rtl/sr_gate_seq.sv
module sr_gate_seq
    import sr_seq_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_CH-1:0]         turn_on_flag,
    input  logic [NUM_CH-1:0]         turn_off_flag,
    input  logic [NUM_CH-1:0]         rearm_flag,
    input  logic [CNT_W-1:0]          min_on_cnt,
    input  logic [CNT_W-1:0]          blank_cnt,
    output logic [NUM_CH-1:0]         gate_en,
    output logic [STATE_W*NUM_CH-1:0] chan_state,
    output logic [NUM_CH-1:0]         early_off
);

    localparam int FLAG_W = 3 * NUM_CH;

    logic [FLAG_W-1:0] flags_sync;
    logic [NUM_CH-1:0] on_s, off_s, rearm_s;

    sr_flag_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({rearm_flag, turn_off_flag, turn_on_flag}),
        .sync_out (flags_sync)
    );

    assign {rearm_s, off_s, on_s} = flags_sync;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            sr_chan_fsm #(.CNT_W(CNT_W)) i_fsm (
                .clk        (clk),
                .rst        (rst),
                .on_s       (on_s[c]),
                .off_s      (off_s[c]),
                .rearm_s    (rearm_s[c]),
                .min_on_cnt (min_on_cnt),
                .blank_cnt  (blank_cnt),
                .gate_en    (gate_en[c]),
                .state_code (chan_state[STATE_W*c +: STATE_W]),
                .early_off  (early_off[c])
            );
        end
    endgenerate

endmodule

// File: tb/test_sr_gate_seq.sv
module test_sr_gate_seq;

    localparam int NUM_CH = 2;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_CH-1:0] on_raw = '0, off_raw = '0, rearm_raw = '0;
    logic [CNT_W-1:0]  mot = 8'd4, blank = 8'd6;
    logic [NUM_CH-1:0] gate, early;
    logic [3*NUM_CH-1:0] st;

    sr_gate_seq #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_sr_gate_seq (
        .clk(clk), .rst(rst),
        .turn_on_flag(on_raw), .turn_off_flag(off_raw), .rearm_flag(rearm_raw),
        .min_on_cnt(mot), .blank_cnt(blank),
        .gate_en(gate), .chan_state(st), .early_off(early)
    );

    always #4 clk = ~clk;

    typedef struct {
        int       cyc;
        int       ch;
        int       st;
        logic     g;
        logic     e;
        string    tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic tick(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic expect_at(int dt, int ch, int s, logic g, logic e, string tag);
        exp_t it;
        int   pos;
        it.cyc = cyc + dt; it.ch = ch; it.st = s; it.g = g; it.e = e; it.tag = tag;
        pos = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].cyc > it.cyc) begin pos = i; break; end
        end
        q.insert(pos, it);
    endtask

    // monitor: pops expectations due this cycle and compares
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t it;
            int   as;
            logic ag, ae;
            it = q.pop_front();
            as = int'(st[3*it.ch +: 3]);
            ag = gate[it.ch];
            ae = early[it.ch];
            checks++;
            if (it.cyc < cyc || as != it.st || ag !== it.g || ae !== it.e) begin
                fails++;
                $display("FAIL %s ch%0d cyc%0d: state=%0d gate=%0b early=%0b expected state=%0d gate=%0b early=%0b",
                         it.tag, it.ch, it.cyc, as, ag, ae, it.st, it.g, it.e);
            end
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        expect_at(1, 0, 0, 0, 0, "R1");
        expect_at(1, 1, 0, 0, 0, "R1");
        tick(2);

        // R2: turn-on ignored while waiting for re-arm
        on_raw[0] = 1'b1;
        expect_at(3, 0, 0, 0, 0, "R2");
        expect_at(5, 0, 0, 0, 0, "R2");
        tick(6);
        on_raw[0] = 1'b0;
        tick(3);
        rearm_raw[0] = 1'b1;
        expect_at(3, 0, 1, 0, 0, "R2");
        tick(1);
        rearm_raw[0] = 1'b0;
        tick(4);

        // R3/R4/R5: turn on, masked off pulse inside min on-time (M=4)
        on_raw[0] = 1'b1;
        expect_at(2, 0, 1, 0, 0, "R3");
        expect_at(3, 0, 2, 1, 0, "R3");
        expect_at(5, 0, 2, 1, 0, "R4");
        expect_at(7, 0, 2, 1, 0, "R4");
        expect_at(8, 0, 3, 1, 0, "R5");
        tick(1);
        off_raw[0] = 1'b1;
        tick(2);
        off_raw[0] = 1'b0;
        tick(2);
        on_raw[0] = 1'b0;
        tick(5);

        // R5/R6/R7: off in ON, blanking B=6, turn-on during blanking
        off_raw[0] = 1'b1;
        expect_at(3, 0, 4, 0, 0, "R5");
        expect_at(8, 0, 4, 0, 0, "R6");
        expect_at(9, 0, 4, 0, 0, "R7");
        expect_at(10, 0, 0, 0, 0, "R7");
        expect_at(12, 0, 0, 0, 0, "R2");
        tick(1);
        on_raw[0] = 1'b1;
        tick(12);
        on_raw[0] = 1'b0;
        off_raw[0] = 1'b0;
        tick(3);

        // R9: zero min on-time
        mot = 8'd0;
        rearm_raw[0] = 1'b1;
        tick(1);
        rearm_raw[0] = 1'b0;
        tick(3);
        on_raw[0] = 1'b1;
        expect_at(3, 0, 2, 1, 0, "R9");
        expect_at(4, 0, 3, 1, 0, "R13");
        tick(6);
        on_raw[0] = 1'b0;

        // R8: re-arm inside blanking before expiry
        off_raw[0] = 1'b1;
        expect_at(3, 0, 4, 0, 0, "R5");
        tick(1);
        off_raw[0] = 1'b0;
        tick(1);
        rearm_raw[0] = 1'b1;
        expect_at(3, 0, 1, 0, 0, "R8");
        tick(1);
        rearm_raw[0] = 1'b0;
        tick(4);

        // R10/R11/R9: off held through end of min on-time, count changed mid-window, B=0
        mot = 8'd3;
        blank = 8'd0;
        on_raw[0] = 1'b1;
        expect_at(6, 0, 2, 1, 0, "R11");
        expect_at(7, 0, 4, 0, 1, "R10");
        expect_at(8, 0, 0, 0, 0, "R9");
        tick(2);
        off_raw[0] = 1'b1;
        tick(2);
        mot = 8'd200;
        tick(7);
        on_raw[0] = 1'b0;
        off_raw[0] = 1'b0;
        mot = 8'd4;
        blank = 8'd6;
        tick(3);

        // R12: channel 1 runs, channel 0 stays locked out
        rearm_raw = 2'b10;
        expect_at(3, 1, 1, 0, 0, "R12");
        expect_at(3, 0, 0, 0, 0, "R12");
        tick(1);
        rearm_raw = 2'b00;
        tick(3);
        on_raw = 2'b11;
        expect_at(3, 1, 2, 1, 0, "R12");
        expect_at(3, 0, 0, 0, 0, "R12");
        tick(4);
        on_raw = 2'b00;
        tick(10);

        while (q.size() > 0) tick(1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule